// File: doc/BRIEF.md
# Filtered Set-Associative Instruction Cache

This block is a read-only cache for instruction fetches. It sits between the processor's instruction port and the flash memory controller. Each fetch first passes an address filter. Only addresses inside a parameterised on-chip flash window are looked up in the cache. Every other fetch goes straight to memory untouched. The block holds 128 words of 32 bits, kept as 16 lines of 8 words, grouped into 4 sets of 4 ways.

A line does not fill as a whole. Every word has its own valid flag, and only the word the processor asked for is written when memory returns it. A fetch that matches a line's tag but finds its word not yet present fills that word in place. In that case no new way is chosen. When a new tag needs room, a per-set round-robin pointer picks the way, and all of that way's word flags are cleared first. Fetches marked as interrupt context can be kept from writing into the cache. A global disable input makes every fetch bypass the cache. Two counters record hits and misses while counting is enabled. An invalidate input empties the whole cache in one cycle.

Top module: `insn_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and both counters read 0.
- R2: A fetch outside the flash window (default window: addresses below 0x0010_0000) raises `mem_req` in the next cycle with the same address. It is never stored and never counted, so a repeat of it goes to memory again.
- R3: A fetch that hits raises `rsp_valid` with the stored word one cycle after acceptance, without any memory request.
- R4: On a miss, `mem_req` pulses for exactly one cycle. `rsp_valid` rises one cycle after `mem_rvalid`, carrying `mem_rdata`, and the requested word becomes valid.
- R5: Only the requested word of a line is filled. A later fetch of another word in the same line misses and is filled in place in the way already holding that tag, so no other way is displaced.
- R6: A new tag takes the way named by its set's round-robin pointer, and the pointer then advances by one (way 0, 1, 2, 3, 0, …). Filling a word in place does not move the pointer.
- R7: While `irq_fill_off` is 1, a fetch with `req_irq` = 1 that misses is served from memory but not stored. Hits are still served from the cache in that case.
- R8: The cache is enabled after reset. While `cache_off` is 1, every fetch goes to memory, nothing is stored, and neither counter moves.
- R9: `hit_cnt` and `miss_cnt` advance by one for each looked-up fetch that hits or misses, and only while `cnt_en` is 1.
- R10: A one-cycle `invalidate` clears every valid flag by the next cycle. It also cancels the fill of any outstanding miss, including a fill that would land in the same cycle.
- R11: The byte address splits into a 2-bit byte offset (bits 1:0), a 3-bit word index (bits 4:2), a 2-bit set index (bits 6:5) and the tag (bits 31:7). Sets are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fetch request, taken when `req_ready` is 1 |
| req_addr | input | 32 | Fetch byte address |
| req_irq | input | 1 | Fetch belongs to interrupt context |
| req_ready | output | 1 | Block can take a new fetch |
| rsp_valid | output | 1 | Fetch data valid, one-cycle pulse |
| rsp_data | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Memory read request, one-cycle pulse |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| cache_off | input | 1 | Bypass the cache completely |
| irq_fill_off | input | 1 | Block fills from interrupt-context fetches |
| cnt_en | input | 1 | Enable the hit and miss counters |
| invalidate | input | 1 | Clear all valid flags |
| hit_cnt | output | 16 | Hit counter |
| miss_cnt | output | 16 | Miss counter |

## Verification
Two events can coincide: a fill arriving from memory and an invalidate pulse. The bench provokes this by raising `invalidate` on the exact cycle that `mem_rvalid` returns for an outstanding flash miss. It then judges two things. The processor must still receive the memory word on time. A repeat fetch of that address must miss again, which shows the fill was dropped rather than written into the emptied cache.

// File: rtl/icf_pkg.sv
package icf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } icf_state_e;
endpackage

// File: rtl/icf_filter.sv
module icf_filter #(
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   FLASH_BASE = '0,
    parameter int              FLASH_LOG2 = 20
) (
    input  logic [AW-1:0] addr,
    input  logic          irq,
    input  logic          cache_off,
    input  logic          irq_fill_off,
    output logic          lk_en,
    output logic          fill_ok
);
    logic in_flash;

    always_comb begin
        in_flash = (addr[AW-1:FLASH_LOG2] == FLASH_BASE[AW-1:FLASH_LOG2]);
        lk_en    = in_flash && !cache_off;
        fill_ok  = lk_en && !(irq && irq_fill_off);
    end
endmodule

// File: rtl/icf_lookup.sv
module icf_lookup #(
    parameter int WAYS  = 4,
    parameter int WORDS = 8,
    parameter int TAG_W = 25,
    parameter int DW    = 32,
    localparam int OFF_W = $clog2(WORDS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0]           rd_tag,
    input  logic [WAYS-1:0][WORDS-1:0]           rd_vld,
    input  logic [WAYS-1:0][WORDS-1:0][DW-1:0]   rd_dat,
    input  logic [TAG_W-1:0]                     tag,
    input  logic [OFF_W-1:0]                     word,
    output logic                                 tag_hit,
    output logic                                 hit,
    output logic [WAY_W-1:0]                     hit_way,
    output logic [DW-1:0]                        hit_data
);
    logic [WAYS-1:0] match;
    logic [WAYS-1:0] word_ok;

    // A way only counts as holding a tag while one of its words is valid.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g]   = (rd_tag[g] == tag) && (|rd_vld[g]);
        assign word_ok[g] = rd_vld[g][word];
    end

    always_comb begin
        tag_hit  = |match;
        hit      = |(match & word_ok);
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way  = WAY_W'(w);
                hit_data = rd_dat[w][word];
            end
        end
    end
endmodule

// File: rtl/icf_store.sv
module icf_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 4,
    parameter int WORDS = 8,
    parameter int TAG_W = 25,
    parameter int DW    = 32,
    localparam int OFF_W = $clog2(WORDS),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SET_W-1:0]                     rd_set,
    input  logic                                 wr_en,
    input  logic                                 wr_alloc,
    input  logic [SET_W-1:0]                     wr_set,
    input  logic [WAY_W-1:0]                     wr_way,
    input  logic [OFF_W-1:0]                     wr_word,
    input  logic [TAG_W-1:0]                     wr_tag,
    input  logic [DW-1:0]                        wr_data,
    input  logic                                 inval,
    output logic [WAYS-1:0][TAG_W-1:0]           rd_tag,
    output logic [WAYS-1:0][WORDS-1:0]           rd_vld,
    output logic [WAYS-1:0][WORDS-1:0][DW-1:0]   rd_dat,
    output logic [WAY_W-1:0]                     victim,
    output logic                                 vld_any
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]         tag;
        logic [SETS-1:0][WAYS-1:0][WORDS-1:0]         vld;
        logic [SETS-1:0][WAYS-1:0][WORDS-1:0][DW-1:0] dat;
        logic [SETS-1:0][WAY_W-1:0]                   rr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_alloc) begin
                st_d.vld[wr_set][wr_way] = '0;
                st_d.tag[wr_set][wr_way] = wr_tag;
                if (st_q.rr[wr_set] == WAY_W'(WAYS - 1)) begin
                    st_d.rr[wr_set] = '0;
                end else begin
                    st_d.rr[wr_set] = st_q.rr[wr_set] + WAY_W'(1);
                end
            end
            st_d.vld[wr_set][wr_way][wr_word] = 1'b1;
            st_d.dat[wr_set][wr_way][wr_word] = wr_data;
        end
        // Invalidate overrides any fill landing in the same cycle.
        if (inval) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tag  = st_q.tag[rd_set];
    assign rd_vld  = st_q.vld[rd_set];
    assign rd_dat  = st_q.dat[rd_set];
    assign victim  = st_q.rr[wr_set];
    assign vld_any = |st_q.vld;
endmodule

// File: rtl/insn_cache.sv
module insn_cache
    import icf_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter int            WAYS       = 4,
    parameter int            SETS       = 4,
    parameter int            LINE_WORDS = 8,
    parameter logic [AW-1:0] FLASH_BASE = '0,
    parameter int            FLASH_LOG2 = 20,
    parameter int            CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_irq,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             cache_off,
    input  logic             irq_fill_off,
    input  logic             cnt_en,
    input  logic             invalidate,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam int BYTE_W = $clog2(DW / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = AW - SET_W - OFF_W - BYTE_W;

    typedef struct packed {
        icf_state_e         st;
        logic               rsp_v;
        logic [DW-1:0]      rsp_d;
        logic               mreq;
        logic [AW-1:0]      maddr;
        logic [SET_W-1:0]   p_set;
        logic [OFF_W-1:0]   p_word;
        logic [TAG_W-1:0]   p_tag;
        logic               p_alloc;
        logic [WAY_W-1:0]   p_way;
        logic               p_fill;
        logic [CNT_W-1:0]   hits;
        logic [CNT_W-1:0]   misses;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [OFF_W-1:0] a_word;
    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;

    assign a_word = req_addr[BYTE_W +: OFF_W];
    assign a_set  = req_addr[BYTE_W + OFF_W +: SET_W];
    assign a_tag  = req_addr[AW-1 -: TAG_W];

    logic f_lk_en, f_fill_ok;

    icf_filter #(
        .AW(AW), .FLASH_BASE(FLASH_BASE), .FLASH_LOG2(FLASH_LOG2)
    ) u_filter (
        .addr(req_addr), .irq(req_irq), .cache_off(cache_off),
        .irq_fill_off(irq_fill_off), .lk_en(f_lk_en), .fill_ok(f_fill_ok)
    );

    logic [WAYS-1:0][TAG_W-1:0]              s_tag;
    logic [WAYS-1:0][LINE_WORDS-1:0]         s_vld;
    logic [WAYS-1:0][LINE_WORDS-1:0][DW-1:0] s_dat;
    logic [WAY_W-1:0]                        s_victim;
    logic                                    st_vld_any;
    logic                                    w_en;
    logic [WAY_W-1:0]                        w_way;

    icf_store #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(LINE_WORDS), .TAG_W(TAG_W), .DW(DW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(a_set),
        .wr_en(w_en), .wr_alloc(c_q.p_alloc), .wr_set(c_q.p_set),
        .wr_way(w_way), .wr_word(c_q.p_word), .wr_tag(c_q.p_tag),
        .wr_data(mem_rdata), .inval(invalidate),
        .rd_tag(s_tag), .rd_vld(s_vld), .rd_dat(s_dat),
        .victim(s_victim), .vld_any(st_vld_any)
    );

    logic             lk_tag_hit, lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic [DW-1:0]    lk_data;

    icf_lookup #(
        .WAYS(WAYS), .WORDS(LINE_WORDS), .TAG_W(TAG_W), .DW(DW)
    ) u_lookup (
        .rd_tag(s_tag), .rd_vld(s_vld), .rd_dat(s_dat),
        .tag(a_tag), .word(a_word),
        .tag_hit(lk_tag_hit), .hit(lk_hit), .hit_way(lk_way), .hit_data(lk_data)
    );

    always_comb begin
        c_d        = c_q;
        c_d.rsp_v  = 1'b0;
        c_d.mreq   = 1'b0;
        w_en       = 1'b0;
        w_way      = c_q.p_alloc ? s_victim : c_q.p_way;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (f_lk_en && lk_hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = lk_data;
                        if (cnt_en) c_d.hits = c_q.hits + CNT_W'(1);
                    end else begin
                        c_d.st      = ST_WAIT;
                        c_d.mreq    = 1'b1;
                        c_d.maddr   = req_addr;
                        c_d.p_set   = a_set;
                        c_d.p_word  = a_word;
                        c_d.p_tag   = a_tag;
                        c_d.p_alloc = !lk_tag_hit;
                        c_d.p_way   = lk_way;
                        c_d.p_fill  = f_fill_ok;
                        if (f_lk_en && cnt_en) c_d.misses = c_q.misses + CNT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (invalidate) c_d.p_fill = 1'b0;
                if (mem_rvalid) begin
                    c_d.st    = ST_IDLE;
                    c_d.rsp_v = 1'b1;
                    c_d.rsp_d = mem_rdata;
                    w_en      = c_q.p_fill && !invalidate;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready = (c_q.st == ST_IDLE);
    assign rsp_valid = c_q.rsp_v;
    assign rsp_data  = c_q.rsp_d;
    assign mem_req   = c_q.mreq;
    assign mem_addr  = c_q.maddr;
    assign hit_cnt   = c_q.hits;
    assign miss_cnt  = c_q.misses;
endmodule

// File: rtl/icf_chk.sv
module icf_chk #(
    parameter int            AW         = 32,
    parameter int            CNT_W      = 16,
    parameter logic [AW-1:0] FLASH_BASE = '0,
    parameter int            FLASH_LOG2 = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_addr,
    input logic             cache_off,
    input logic             lk_en,
    input logic             lk_hit,
    input logic             rsp_valid,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr,
    input logic             cnt_en,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic             invalidate,
    input logic             vld_any
);
    logic acc;
    logic outside;
    assign acc     = req_valid && req_ready;
    assign outside = (req_addr[AW-1:FLASH_LOG2] != FLASH_BASE[AW-1:FLASH_LOG2]);

    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && outside) |=> (mem_req && mem_addr == $past(req_addr)));

    p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lk_en && lk_hit) |=> (rsp_valid && !mem_req));

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_off_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cache_off) |=> mem_req);

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> ($stable(hit_cnt) && $stable(miss_cnt)));

    p_inval_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !vld_any);
endmodule

bind insn_cache icf_chk #(
    .AW(AW), .CNT_W(CNT_W), .FLASH_BASE(FLASH_BASE), .FLASH_LOG2(FLASH_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cache_off(cache_off), .lk_en(f_lk_en), .lk_hit(lk_hit),
    .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_addr(mem_addr),
    .cnt_en(cnt_en), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
    .invalidate(invalidate), .vld_any(st_vld_any)
);

// File: tb/insn_cache_bench.sv
module insn_cache_bench;
    localparam logic [31:0] SALT = 32'h5A3C_0000;
    localparam int NV = 21;
    // {address, requirement number, expected latency in cycles}
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_0080, 4'd4,  2'd2},  // R4 first miss, way 0
        {32'h0000_0080, 4'd3,  2'd1},  // R3 hit
        {32'h0000_0084, 4'd5,  2'd2},  // R5 other word misses
        {32'h0000_0084, 4'd5,  2'd1},
        {32'h0000_0100, 4'd4,  2'd2},
        {32'h0000_0180, 4'd4,  2'd2},
        {32'h0000_0200, 4'd4,  2'd2},
        {32'h0000_0080, 4'd5,  2'd1},  // R5 in-place fill kept way 0
        {32'h0000_0280, 4'd6,  2'd2},  // R6 evicts way 0
        {32'h0000_0080, 4'd6,  2'd2},  // R6 evicted, takes way 1
        {32'h0000_0180, 4'd6,  2'd1},
        {32'h0000_0100, 4'd6,  2'd2},  // R6 way 1 was taken
        {32'h0000_0280, 4'd6,  2'd1},
        {32'h0000_00A0, 4'd11, 2'd2},  // R11 set 1 independent
        {32'h0000_00A0, 4'd11, 2'd1},
        {32'h2000_0000, 4'd2,  2'd2},  // R2 bypass
        {32'h2000_0000, 4'd2,  2'd2},
        {32'h000F_FFFC, 4'd2,  2'd2},  // R2 last flash word
        {32'h000F_FFFC, 4'd2,  2'd1},
        {32'h0010_0000, 4'd2,  2'd2},  // R2 first word past flash
        {32'h0010_0000, 4'd2,  2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_irq = 1'b0;
    logic        req_ready, rsp_valid, mem_req;
    logic [31:0] rsp_data, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cache_off = 1'b0;
    logic        irq_fill_off = 1'b0;
    logic        cnt_en = 1'b1;
    logic        invalidate = 1'b0;
    logic [15:0] hit_cnt, miss_cnt;
    logic [31:0] last_ma = '0;

    int total = 0;
    int bad = 0;
    int eh = 0;
    int em = 0;
    bit done = 0;

    always #10 clk = ~clk;

    insn_cache u_insn_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_irq(req_irq), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cache_off(cache_off),
        .irq_fill_off(irq_fill_off), .cnt_en(cnt_en), .invalidate(invalidate),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    // Memory model: answers a request on the following cycle.
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid <= mem_req;
            mem_rdata  <= mem_req ? (mem_addr ^ SALT) : '0;
            if (mem_req) last_ma <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit in_flash(input logic [31:0] a);
        return a < 32'h0010_0000;
    endfunction

    task automatic access(input logic [31:0] a, input logic irq,
                          input int exp_lat, input string rq);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_irq = irq;
        @(negedge clk);
        req_valid = 1'b0; req_irq = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, rq, "latency", lat, exp_lat);
        chk(rsp_data == (a ^ SALT), rq, "data", rsp_data, a ^ SALT);
        if (!in_flash(a) && exp_lat == 2) chk(last_ma == a, rq, "mem_addr", last_ma, a);
        if (cnt_en && !cache_off && in_flash(a)) begin
            if (exp_lat == 1) eh++; else em++;
        end
    endtask

    task automatic cnt_check(input string rq);
        chk(hit_cnt == 16'(eh), rq, "hit_cnt", hit_cnt, eh);
        chk(miss_cnt == 16'(em), rq, "miss_cnt", miss_cnt, em);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
        cnt_check("R1");

        // Table walk; R8: the hit in entry 2 shows the cache is on after reset.
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][37:6], 1'b0, int'(VEC[i][1:0]),
                   $sformatf("R%0d", VEC[i][5:2]));
        end
        cnt_check("R9");

        // R9 counting disabled
        cnt_en = 1'b0;
        access(32'h0000_0080, 1'b0, 1, "R9");
        access(32'h0000_0300, 1'b0, 2, "R9");
        cnt_check("R9");
        cnt_en = 1'b1;

        // R7 interrupt-context fills blocked
        irq_fill_off = 1'b1;
        access(32'h0000_1000, 1'b1, 2, "R7");
        access(32'h0000_1000, 1'b1, 2, "R7");
        access(32'h0000_1000, 1'b0, 2, "R7");
        access(32'h0000_1000, 1'b1, 1, "R7");
        irq_fill_off = 1'b0;
        access(32'h0000_1020, 1'b1, 2, "R7");
        access(32'h0000_1020, 1'b1, 1, "R7");
        cnt_check("R7");

        // R8 disable bypasses everything
        cache_off = 1'b1;
        access(32'h0000_1020, 1'b0, 2, "R8");
        access(32'h0000_1040, 1'b0, 2, "R8");
        cnt_check("R8");
        cache_off = 1'b0;
        access(32'h0000_1040, 1'b0, 2, "R8");
        access(32'h0000_1040, 1'b0, 1, "R8");

        // R10 invalidate clears everything
        @(negedge clk); invalidate = 1'b1;
        @(negedge clk); invalidate = 1'b0;
        access(32'h0000_1040, 1'b0, 2, "R10");
        access(32'h0000_1020, 1'b0, 2, "R10");

        // R10 invalidate in the same cycle as a fill
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_1060;
        @(negedge clk);
        req_valid = 1'b0;
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        chk(rsp_valid == 1'b1, "R10", "collide rsp_valid", rsp_valid, 1);
        chk(rsp_data == (32'h0000_1060 ^ SALT), "R10", "collide data",
            rsp_data, 32'h0000_1060 ^ SALT);
        em++;
        access(32'h0000_1060, 1'b0, 2, "R10");
        access(32'h0000_1060, 1'b0, 1, "R10");
        cnt_check("R9");

        done = 1;
        summary();
    end
endmodule